// File: doc/BRIEF.md
# Bit Test and Bit Scan Unit

This unit carries out single-bit operations and first-one searches on one data word. A bit-test request picks one bit of the operand with an index. The old value of that bit comes back as the carry. The operand comes back either unchanged or with the picked bit forced high, forced low or flipped.

A scan request searches the operand for a one bit, starting from the least significant end or from the most significant end. It returns the position of the first one it finds. It also raises a zero indicator when the operand holds no one bits at all.

A request is presented with `validIn` for one cycle. The answer appears on registered outputs one clock later, marked by `validOut`. A request only updates the outputs that belong to its own kind of operation; every other output keeps its earlier value.

Top module: `bitTestScanUnit`

## Requirements
- R1: While `rst` is high at a rising edge, `result`, `carry`, `zeroFlag` and `validOut` become 0.
- R2: `validOut` is 1 in the cycle after a cycle with `validIn` high, and 0 otherwise. The outputs for a request appear in that same cycle.
- R3: Opcode 0 (test) sets `carry` to the addressed operand bit. `result` is the operand unchanged.
- R4: Opcode 1 (test-and-set), opcode 2 (test-and-clear) and opcode 3 (test-and-flip) set `carry` to the old addressed bit. `result` is the operand with that bit forced to 1, forced to 0 or inverted, in that order.
- R5: The bit position used by opcodes 0 to 3 is `index` modulo DATA_W, which is the low 5 bits for the default width of 32.
- R6: Opcode 4 (scan up) on a nonzero operand sets `result` to the position of its lowest one bit, zero-extended, and sets `zeroFlag` to 0.
- R7: Opcode 5 (scan down) on a nonzero operand sets `result` to the position of its highest one bit, zero-extended, and sets `zeroFlag` to 0.
- R8: Opcode 4 or 5 on an all-zero operand sets `zeroFlag` to 1 and leaves `result` at its previous value.
- R9: Opcodes 0 to 3 leave `zeroFlag` unchanged. Opcodes 4 and 5 leave `carry` unchanged.
- R10: A cycle with `validIn` low changes none of `result`, `carry` or `zeroFlag`, whatever the other inputs carry.
- R11: Opcodes 6 and 7 behave exactly like opcode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Request strobe |
| opcode | input | 3 | Operation select (0..7) |
| operand | input | DATA_W (32) | Source word |
| index | input | INDEX_W (8) | Bit position, used modulo DATA_W |
| result | output | DATA_W (32) | Modified word or found bit position |
| carry | output | 1 | Old value of the addressed bit |
| zeroFlag | output | 1 | Operand of the last scan was all zeros |
| validOut | output | 1 | Outputs carry a fresh answer |

## Verification
The bench builds the unit with its default parameters: DATA_W of 32 and INDEX_W of 8. The 8-bit index port is wider than the 5 bits a 32-bit word needs, so the bench can drive indices of 32 and above and show the modulo wrap. The 32-bit width lets the vectors place one bits at both ends and in the middle of the word, which covers the edge positions 0 and 31 for both scan directions. The vector table runs scans and tests in an order chosen so that the held values of `result`, `carry` and `zeroFlag` are checked after each kind of request.

// File: rtl/bitTestScanPkg.sv
package bitTestScanPkg;

  typedef enum logic [2:0] {
    OP_TEST   = 3'd0,
    OP_SET    = 3'd1,
    OP_CLEAR  = 3'd2,
    OP_FLIP   = 3'd3,
    OP_SCANUP = 3'd4,
    OP_SCANDN = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    MOD_NONE  = 2'd0,
    MOD_SET   = 2'd1,
    MOD_CLEAR = 2'd2,
    MOD_FLIP  = 2'd3
  } modKind_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic     loadResult;
    logic     loadCarry;
    logic     loadZero;
    logic     selScan;
    logic     scanFromTop;
    modKind_e modKind;
  } strobes_t;

endpackage

// File: rtl/bitTestScanCtrl.sv
module bitTestScanCtrl
  import bitTestScanPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       validIn,
  input  logic [2:0] opcode,
  input  logic       srcIsZero,
  output strobes_t   strobes,
  output logic       validOut
);

  always_comb begin
    strobes = '0;
    strobes.modKind = MOD_NONE;
    unique case (opcode)
      OP_SET:   strobes.modKind = MOD_SET;
      OP_CLEAR: strobes.modKind = MOD_CLEAR;
      OP_FLIP:  strobes.modKind = MOD_FLIP;
      default:  strobes.modKind = MOD_NONE;
    endcase
    if (opcode == OP_SCANUP || opcode == OP_SCANDN) begin
      strobes.selScan     = 1'b1;
      strobes.scanFromTop = (opcode == OP_SCANDN);
      strobes.loadZero    = validIn;
      strobes.loadResult  = validIn && !srcIsZero;
      strobes.loadCarry   = 1'b0;
    end else begin
      strobes.loadResult  = validIn;
      strobes.loadCarry   = validIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= validIn;
  end

endmodule

// File: rtl/bitTestScanPath.sv
module bitTestScanPath
  import bitTestScanPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  strobes_t           strobes,
  input  logic [DATA_W-1:0]  operand,
  input  logic [INDEX_W-1:0] index,
  output logic               srcIsZero,
  output logic [DATA_W-1:0]  result,
  output logic               carry,
  output logic               zeroFlag
);

  localparam int POS_W = $clog2(DATA_W);

  logic [POS_W-1:0]  bitSel;
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] modified;
  logic              oldBit;
  logic [POS_W-1:0]  lowPos;
  logic [POS_W-1:0]  highPos;
  logic [DATA_W-1:0] scanWord;
  logic [DATA_W-1:0] nextResult;

  assign bitSel    = POS_W'(index % INDEX_W'(DATA_W));
  assign bitMask   = DATA_W'(1) << bitSel;
  assign oldBit    = operand[bitSel];
  assign srcIsZero = (operand == '0);

  always_comb begin
    unique case (strobes.modKind)
      MOD_SET:   modified = operand | bitMask;
      MOD_CLEAR: modified = operand & ~bitMask;
      MOD_FLIP:  modified = operand ^ bitMask;
      default:   modified = operand;
    endcase
  end

  // Lowest one: walk down so the last hit is the smallest position
  always_comb begin
    lowPos = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (operand[i]) lowPos = POS_W'(i);
    end
  end

  // Highest one: walk up so the last hit is the largest position
  always_comb begin
    highPos = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (operand[i]) highPos = POS_W'(i);
    end
  end

  assign scanWord   = strobes.scanFromTop ? DATA_W'(highPos) : DATA_W'(lowPos);
  assign nextResult = strobes.selScan ? scanWord : modified;

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      carry    <= 1'b0;
      zeroFlag <= 1'b0;
    end else begin
      if (strobes.loadResult) result   <= nextResult;
      if (strobes.loadCarry)  carry    <= oldBit;
      if (strobes.loadZero)   zeroFlag <= srcIsZero;
    end
  end

endmodule

// File: rtl/bitTestScanUnit.sv
module bitTestScanUnit
  import bitTestScanPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               validIn,
  input  logic [2:0]         opcode,
  input  logic [DATA_W-1:0]  operand,
  input  logic [INDEX_W-1:0] index,
  output logic [DATA_W-1:0]  result,
  output logic               carry,
  output logic               zeroFlag,
  output logic               validOut
);

  strobes_t strobes;
  logic     srcIsZero;

  bitTestScanCtrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .opcode   (opcode),
    .srcIsZero(srcIsZero),
    .strobes  (strobes),
    .validOut (validOut)
  );

  bitTestScanPath #(
    .DATA_W (DATA_W),
    .INDEX_W(INDEX_W)
  ) i_path (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .operand  (operand),
    .index    (index),
    .srcIsZero(srcIsZero),
    .result   (result),
    .carry    (carry),
    .zeroFlag (zeroFlag)
  );

endmodule

// File: rtl/bitTestScanChecker.sv
module bitTestScanChecker #(
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               validIn,
  input logic [2:0]         opcode,
  input logic [DATA_W-1:0]  operand,
  input logic [INDEX_W-1:0] index,
  input logic [DATA_W-1:0]  result,
  input logic               carry,
  input logic               zeroFlag,
  input logic               validOut
);

  localparam logic [DATA_W-1:0] TOP_ONE = {1'b1, {(DATA_W-1){1'b0}}};

  logic isTestOp;
  logic isScanOp;
  logic refBit;
  assign isTestOp = (opcode < 3'd4) || (opcode > 3'd5);
  assign isScanOp = !isTestOp;
  assign refBit   = (operand >> (index % INDEX_W'(DATA_W))) & DATA_W'(1) ? 1'b1 : 1'b0;

  // R2: one-cycle valid latency
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> validOut == $past(validIn));

  // R3 and R11: plain test returns operand and old bit
  a_r3_plain_test: assert property (@(posedge clk) disable iff (rst)
    validIn && (opcode == 3'd0 || opcode > 3'd5) |=>
      result == $past(operand) && carry == $past(refBit));

  // R4: modify variants report the old bit
  a_r4_old_bit_in_carry: assert property (@(posedge clk) disable iff (rst)
    validIn && opcode >= 3'd1 && opcode <= 3'd3 |=> carry == $past(refBit));

  // R6: scan up lands on the lowest one
  a_r6_scan_up_lowest: assert property (@(posedge clk) disable iff (rst)
    validIn && opcode == 3'd4 && operand != '0 |=>
      result < DATA_W && ($past(operand) << (DATA_W - 1 - result)) == TOP_ONE && !zeroFlag);

  // R7: scan down lands on the highest one
  a_r7_scan_down_highest: assert property (@(posedge clk) disable iff (rst)
    validIn && opcode == 3'd5 && operand != '0 |=>
      ($past(operand) >> result) == DATA_W'(1) && !zeroFlag);

  // R8: empty source raises the flag and holds the result
  a_r8_empty_scan: assert property (@(posedge clk) disable iff (rst)
    validIn && isScanOp && operand == '0 |=> zeroFlag && $stable(result));

  // R9: each kind keeps the other kind's flag
  a_r9_test_keeps_zero: assert property (@(posedge clk) disable iff (rst)
    validIn && isTestOp |=> $stable(zeroFlag));
  a_r9_scan_keeps_carry: assert property (@(posedge clk) disable iff (rst)
    validIn && isScanOp |=> $stable(carry));

  // R10: idle cycles hold everything
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> $stable(result) && $stable(carry) && $stable(zeroFlag));

endmodule

bind bitTestScanUnit bitTestScanChecker #(
  .DATA_W (DATA_W),
  .INDEX_W(INDEX_W)
) i_checker (
  .clk     (clk),
  .rst     (rst),
  .validIn (validIn),
  .opcode  (opcode),
  .operand (operand),
  .index   (index),
  .result  (result),
  .carry   (carry),
  .zeroFlag(zeroFlag),
  .validOut(validOut)
);

// File: tb/test_bitTestScanUnit.sv
module test_bitTestScanUnit;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int INDEX_W    = 8;
  localparam int NUM_VEC    = 18;

  typedef struct packed {
    logic [23:0]        tag;
    logic [2:0]         op;
    logic [DATA_W-1:0]  src;
    logic [INDEX_W-1:0] idx;
    logic [DATA_W-1:0]  expResult;
    logic               expCarry;
    logic               expZero;
  } vec_t;

  // Applied in order from reset; held values depend on the earlier rows
  localparam vec_t VECS [NUM_VEC] = '{
    '{"R3 ", 3'd0, 32'h0000_0010, 8'd4,  32'h0000_0010, 1'b1, 1'b0},
    '{"R4 ", 3'd1, 32'h0000_0000, 8'd31, 32'h8000_0000, 1'b0, 1'b0},
    '{"R4 ", 3'd2, 32'hFFFF_FFFF, 8'd0,  32'hFFFF_FFFE, 1'b1, 1'b0},
    '{"R4 ", 3'd3, 32'h0F0F_0F0F, 8'd8,  32'h0F0F_0E0F, 1'b1, 1'b0},
    '{"R5 ", 3'd3, 32'h0000_0000, 8'd37, 32'h0000_0020, 1'b0, 1'b0},
    '{"R4 ", 3'd1, 32'h0000_0001, 8'd0,  32'h0000_0001, 1'b1, 1'b0},
    '{"R6 ", 3'd4, 32'h0010_0100, 8'd0,  32'd8,         1'b1, 1'b0},
    '{"R7 ", 3'd5, 32'h0010_0100, 8'd0,  32'd20,        1'b1, 1'b0},
    '{"R8 ", 3'd4, 32'h0000_0000, 8'd0,  32'd20,        1'b1, 1'b1},
    '{"R8 ", 3'd5, 32'h0000_0000, 8'd0,  32'd20,        1'b1, 1'b1},
    '{"R9 ", 3'd0, 32'h8000_0000, 8'd63, 32'h8000_0000, 1'b1, 1'b1},
    '{"R7 ", 3'd5, 32'h0000_0001, 8'd0,  32'd0,         1'b1, 1'b0},
    '{"R6 ", 3'd4, 32'h8000_0000, 8'd0,  32'd31,        1'b1, 1'b0},
    '{"R11", 3'd6, 32'h1234_5678, 8'd3,  32'h1234_5678, 1'b1, 1'b0},
    '{"R11", 3'd7, 32'h0000_0002, 8'd0,  32'h0000_0002, 1'b0, 1'b0},
    '{"R4 ", 3'd2, 32'h0000_0000, 8'd9,  32'h0000_0000, 1'b0, 1'b0},
    '{"R6 ", 3'd4, 32'hFFFF_FFFF, 8'd0,  32'd0,         1'b0, 1'b0},
    '{"R7 ", 3'd5, 32'hFFFF_FFFF, 8'd0,  32'd31,        1'b0, 1'b0}
  };

  logic               clk = 1'b0;
  logic               rst;
  logic               validIn;
  logic [2:0]         opcode;
  logic [DATA_W-1:0]  operand;
  logic [INDEX_W-1:0] index;
  logic [DATA_W-1:0]  result;
  logic               carry;
  logic               zeroFlag;
  logic               validOut;

  int checkCount = 0;
  int failCount  = 0;
  int cycleCount = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bitTestScanUnit #(
    .DATA_W (DATA_W),
    .INDEX_W(INDEX_W)
  ) i_bitTestScanUnit (
    .clk     (clk),
    .rst     (rst),
    .validIn (validIn),
    .opcode  (opcode),
    .operand (operand),
    .index   (index),
    .result  (result),
    .carry   (carry),
    .zeroFlag(zeroFlag),
    .validOut(validOut)
  );

  task automatic check(input string req, input string what,
                       input logic [DATA_W-1:0] actual, input logic [DATA_W-1:0] expected);
    checkCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, actual, expected);
    end
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 5000) begin
      checkCount++;
      failCount++;
      $display("FAIL R2 watchdog: actual %0d cycles expected under 5000", cycleCount);
      $display("  == %0d vectors applied, %0d miscompares ==", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] lastResult;
    logic              lastCarry;
    logic              lastZero;

    rst = 1'b1; validIn = 1'b0; opcode = 3'd0; operand = '0; index = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "result",   result,          '0);
    check("R1", "carry",    DATA_W'(carry),   '0);
    check("R1", "zeroFlag", DATA_W'(zeroFlag),'0);
    check("R1", "validOut", DATA_W'(validOut),'0);
    rst = 1'b0;

    for (int v = 0; v < NUM_VEC; v++) begin
      string tagStr;
      tagStr = string'(VECS[v].tag);
      validIn = 1'b1;
      opcode  = VECS[v].op;
      operand = VECS[v].src;
      index   = VECS[v].idx;
      @(negedge clk);
      validIn = 1'b0;
      check(tagStr, "result",   result,            VECS[v].expResult);
      check(tagStr, "carry",    DATA_W'(carry),    DATA_W'(VECS[v].expCarry));
      check(tagStr, "zeroFlag", DATA_W'(zeroFlag), DATA_W'(VECS[v].expZero));
      check("R2",   "validOut", DATA_W'(validOut), DATA_W'(1));
    end

    // R2: no request, no valid
    @(negedge clk);
    check("R2", "validOut idle", DATA_W'(validOut), '0);

    // R10: idle inputs churn, outputs hold
    lastResult = result; lastCarry = carry; lastZero = zeroFlag;
    opcode = 3'd4; operand = '0; index = 8'd5;
    @(negedge clk);
    opcode = 3'd1; operand = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R10", "result",   result,            lastResult);
    check("R10", "carry",    DATA_W'(carry),    DATA_W'(lastCarry));
    check("R10", "zeroFlag", DATA_W'(zeroFlag), DATA_W'(lastZero));
    check("R10", "validOut", DATA_W'(validOut), '0);

    // R5: index 255 wraps to 31
    validIn = 1'b1; opcode = 3'd3; operand = 32'h0000_0000; index = 8'd255;
    @(negedge clk);
    validIn = 1'b0;
    check("R5", "result wrap", result, 32'h8000_0000);

    // R1: mid-run reset clears state
    validIn = 1'b1; opcode = 3'd5; operand = 32'h0000_0000;
    @(negedge clk);
    validIn = 1'b0;
    check("R8", "zeroFlag", DATA_W'(zeroFlag), DATA_W'(1));
    rst = 1'b1;
    @(negedge clk);
    check("R1", "result after reset",   result,            '0);
    check("R1", "zeroFlag after reset", DATA_W'(zeroFlag), '0);
    rst = 1'b0;
    @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end

endmodule